// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is a two-wire serial bus slave in front of a 256-byte memory, held here as an on-chip register array. SCL and SDA are brought in as plain inputs, passed through synchronizers clocked by the system clock, and decoded into START, STOP and clock-edge events. The slave answers a 7-bit address made of a four-bit prefix and three device-select bits that are compared against strap inputs. It supports single-byte writes, page writes of up to 16 bytes, reads from the current pointer, and sequential reads. SDA is driven low only, as an open-drain pull-down enable.

Two independent guards sit between the bus and the array. A write-control input, sampled at each START, stops every write in that transaction from reaching the array. A software lock is set once by a write addressed with the alternate prefix. After that, bytes aimed at the lower half of the array are dropped and the upper half stays writable. After any write that reaches the array, the slave ignores its own address for a fixed number of system cycles. This stands in for the internal programming time.

Top module: `i2c_prom_slave`

## Requirements
- R1: A transaction starts only on a START (SDA falls while SCL is high) and ends on a STOP (SDA rises while SCL is high). Bits clocked while no transaction is open get no acknowledge.
- R2: The first byte after START is decoded MSB first as prefix[7:4], select[3:1] and direction[0], where 1 is read. The slave acknowledges only if select equals `dev_sel_i` and the prefix is 4'b1010 (either direction) or 4'b0110 (write only). Otherwise SDA stays released on the ninth clock.
- R3: In a memory write, the byte after the address byte loads the pointer. Each data byte is acknowledged by pulling SDA low on the ninth clock and lands at the pointer.
- R4: A page write buffers up to 16 bytes. The low four pointer bits advance per byte and wrap inside the 16-byte page, so a later byte overwrites an earlier one in the same slot.
- R5: Buffered bytes reach the array only on STOP. A repeated START discards them.
- R6: A read returns the byte at the pointer MSB first. The pointer then increments and wraps from 0xFF to 0x00. After reset the pointer is 0x00.
- R7: In a read, the slave sends the next byte when the master pulls SDA low on the ninth clock. When the master leaves SDA high there, the slave stops driving SDA until the next START.
- R8: A write addressed with prefix 4'b0110 is acknowledged and, at its STOP, sets the lock for good. With the lock set, bytes for 0x00 to 0x7F are dropped and bytes for 0x80 to 0xFF are still written.
- R9: If `wr_ctrl_i` is high at START, that transaction writes nothing to the array and does not set the lock. Its bytes are still acknowledged.
- R10: `wr_ctrl_i` is sampled at START only. A change later in the same transaction has no effect on it.
- R11: For BUSY_CYCLES system cycles after a STOP that wrote at least one byte, the slave does not acknowledge any address byte. A transaction whose bytes were all dropped does not start this window.
- R12: Reset releases SDA, clears the lock, sets the pointer to 0x00 and fills the array with 0xFF.
- R13: An address byte with prefix 4'b0110 and the read bit set is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| dev_sel_i | input | 3 | Strapped device-select bits |
| wr_ctrl_i | input | 1 | High blocks all array writes for a transaction |

## Verification
Writes are tried as a single byte, as an 18-byte page burst that wraps inside its page, and as a write cut short by a repeated START. Together these separate correct buffering from commit-on-STOP and from in-page wrapping. Reads run from a set pointer across the 0xFF boundary, as a bare current-address read, and with a master NACK followed by an extra probe clock. This shows whether the pointer advance and the release of SDA are right. Protection is applied in several ways: write-control high from START, write-control raised after START, a lock command issued while write-control is high, then a real lock followed by writes to both halves. Each write case is followed by an immediate address probe, which shows whether the busy window started or not.

// File: rtl/prom_pkg.sv
package prom_pkg;

  localparam int DEV_BYTE_W = 8;
  localparam logic [3:0] PFX_MEM  = 4'b1010;
  localparam logic [3:0] PFX_LOCK = 4'b0110;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } seq_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA
  } rx_kind_e;

  typedef enum logic [1:0] {
    N_WADDR,
    N_WDATA,
    N_TX
  } ack_next_e;

  typedef enum logic [1:0] {
    T_NONE,
    T_MEM_WR,
    T_LOCK,
    T_READ
  } txn_e;

  // Classify the address byte: prefix[7:4], select[3:1], direction[0].
  function automatic txn_e decode_dev(logic [DEV_BYTE_W-1:0] b, logic [2:0] sel);
    if (b[3:1] != sel) return T_NONE;
    if (b[7:4] == PFX_MEM) return b[0] ? T_READ : T_MEM_WR;
    if (b[7:4] == PFX_LOCK && !b[0]) return T_LOCK;
    return T_NONE;
  endfunction

  // A byte may reach the array when write-control was low at START
  // and the target is not in the locked lower half.
  function automatic logic wr_permitted(logic upper_half, logic lock, logic wc);
    return !wc && !(lock && !upper_half);
  endfunction

endpackage

// File: rtl/prom_bus_sense.sv
module prom_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_q, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_q;
      sda_d    <= sda_q;
    end
  end

  assign scl_q    = scl_sync[SYNC_STAGES-1];
  assign sda_q    = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  // Edges on SDA count as bus conditions only while SCL stayed high.
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/prom_guard.sv
module prom_guard #(
  parameter int BUSY_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_req,
  input  logic commit_hit,
  output logic lock_q,
  output logic busy
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_req) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (commit_hit) begin
      busy_cnt <= BW'(BUSY_CYCLES);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign busy = (busy_cnt != '0);

  // R8: once set, the lock never clears
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R11: a committed write opens the busy window
  p_busy_after_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hit |=> busy);

endmodule

// File: rtl/prom_store.sv
module prom_store #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_req,
  input  logic [AW-PW-1:0]              page_base,
  input  logic [(1<<PW)-1:0]            slot_valid,
  input  logic [(1<<PW)-1:0][DW-1:0]    slot_data,
  input  logic                          lock,
  input  logic                          wc,
  input  logic [AW-1:0]                 rd_addr,
  output logic [DW-1:0]                 rd_data,
  output logic                          commit_hit
);

  localparam int NSLOT = 1 << PW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [NSLOT-1:0] lane_we;
  logic             page_ok;

  assign page_ok = prom_pkg::wr_permitted(page_base[AW-PW-1], lock, wc);

  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    assign lane_we[g] = commit_req & slot_valid[g] & page_ok;
  end

  assign commit_hit = |lane_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (lane_we[i]) mem[{page_base, PW'(i)}] <= slot_data[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // R3: a lane write lands in the array at its page slot
  p_commit_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[0] |=> mem[{$past(page_base), PW'(0)}] == $past(slot_data[0]));

endmodule

// File: rtl/prom_seq.sv
module prom_seq #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_rise,
  input  logic                          scl_fall,
  input  logic                          start_ev,
  input  logic                          stop_ev,
  input  logic                          sda_q,
  input  logic [2:0]                    dev_sel,
  input  logic                          wc_in,
  input  logic                          busy,
  input  logic [DW-1:0]                 rd_data,
  output logic [AW-1:0]                 ptr,
  output logic                          sda_pull,
  output logic                          commit_req,
  output logic                          lock_req,
  output logic                          wc_lat,
  output logic [AW-PW-1:0]              page_base,
  output logic [(1<<PW)-1:0]            slot_valid,
  output logic [(1<<PW)-1:0][DW-1:0]    slot_data
);
  import prom_pkg::*;

  localparam int CW = $clog2(DW + 1);

  seq_state_e      state;
  rx_kind_e        kind;
  ack_next_e       nxt;
  txn_e            txn;
  txn_e            dev_txn;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   shreg;
  logic            mack;
  logic            byte_in;

  // Pointer step inside the current page during writes.
  function automatic logic [AW-1:0] page_step(logic [AW-1:0] p);
    return {p[AW-1:PW], p[PW-1:0] + PW'(1)};
  endfunction

  assign dev_txn    = decode_dev(8'(shreg), dev_sel);
  assign byte_in    = (state == S_RX) && scl_fall && (cnt == CW'(DW));
  assign page_base  = ptr[AW-1:PW];
  assign commit_req = stop_ev && (txn == T_MEM_WR);
  assign lock_req   = stop_ev && (txn == T_LOCK) && !wc_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= K_DEV;
      nxt        <= N_WADDR;
      txn        <= T_NONE;
      cnt        <= '0;
      shreg      <= '0;
      ptr        <= '0;
      mack       <= 1'b0;
      sda_pull   <= 1'b0;
      wc_lat     <= 1'b0;
      slot_valid <= '0;
      slot_data  <= '0;
    end else if (start_ev) begin
      state      <= S_RX;
      kind       <= K_DEV;
      cnt        <= '0;
      txn        <= T_NONE;
      wc_lat     <= wc_in;
      slot_valid <= '0;
      sda_pull   <= 1'b0;
    end else if (stop_ev) begin
      state      <= S_IDLE;
      txn        <= T_NONE;
      slot_valid <= '0;
      sda_pull   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RX: begin
          if (scl_rise && cnt < CW'(DW)) begin
            shreg <= {shreg[DW-2:0], sda_q};
            cnt   <= cnt + 1'b1;
          end
          if (byte_in) begin
            unique case (kind)
              K_DEV: begin
                if (dev_txn != T_NONE && !busy) begin
                  txn      <= dev_txn;
                  sda_pull <= 1'b1;
                  state    <= S_ACK;
                  nxt      <= (dev_txn == T_READ)   ? N_TX :
                              (dev_txn == T_MEM_WR) ? N_WADDR : N_WDATA;
                end else begin
                  state <= S_IDLE;
                end
              end
              K_WADDR: begin
                ptr        <= AW'(shreg);
                slot_valid <= '0;
                sda_pull   <= 1'b1;
                state      <= S_ACK;
                nxt        <= N_WDATA;
              end
              K_WDATA: begin
                if (txn == T_MEM_WR) begin
                  slot_data[ptr[PW-1:0]]  <= shreg;
                  slot_valid[ptr[PW-1:0]] <= 1'b1;
                  ptr                     <= page_step(ptr);
                end
                sda_pull <= 1'b1;
                state    <= S_ACK;
                nxt      <= N_WDATA;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            unique case (nxt)
              N_WADDR: begin
                sda_pull <= 1'b0;
                kind     <= K_WADDR;
                state    <= S_RX;
              end
              N_WDATA: begin
                sda_pull <= 1'b0;
                kind     <= K_WDATA;
                state    <= S_RX;
              end
              N_TX: begin
                shreg    <= rd_data;
                sda_pull <= !rd_data[DW-1];
                state    <= S_TX;
              end
              default: begin
                sda_pull <= 1'b0;
                state    <= S_IDLE;
              end
            endcase
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == CW'(DW - 1)) begin
              sda_pull <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= S_MACK;
            end else begin
              shreg    <= {shreg[DW-2:0], 1'b0};
              sda_pull <= !shreg[DW-2];
              cnt      <= cnt + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= !sda_q;
          if (scl_fall) begin
            if (mack) begin
              shreg    <= rd_data;
              sda_pull <= !rd_data[DW-1];
              cnt      <= '0;
              state    <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: START always opens a fresh address byte
  p_start_enters_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == S_RX && kind == K_DEV && cnt == '0));

  // R1: STOP closes the transaction
  p_stop_idles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (state == S_IDLE && !sda_pull));

  // R7: SDA is pulled only in acknowledge or transmit phases
  p_pull_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state == S_ACK || state == S_TX));

  // R11: no address acknowledge while busy
  p_no_ack_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && kind == K_DEV && busy && !start_ev && !stop_ev) |=> !sda_pull);

endmodule

// File: rtl/i2c_prom_slave.sv
module i2c_prom_slave #(
  parameter int MEM_AW      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wr_ctrl_i
);

  localparam int NSLOT = 1 << PAGE_W;

  logic sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, lock_q, lock_req, commit_req, commit_hit, wc_lat;
  logic [MEM_AW-1:0]               ptr;
  logic [DATA_W-1:0]               rd_data;
  logic [MEM_AW-PAGE_W-1:0]        page_base;
  logic [NSLOT-1:0]                slot_valid;
  logic [NSLOT-1:0][DATA_W-1:0]    slot_data;

  prom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  prom_seq #(.AW(MEM_AW), .DW(DATA_W), .PW(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_q(sda_q),
    .dev_sel(dev_sel_i), .wc_in(wr_ctrl_i), .busy(busy), .rd_data(rd_data),
    .ptr(ptr), .sda_pull(sda_pull_o), .commit_req(commit_req),
    .lock_req(lock_req), .wc_lat(wc_lat), .page_base(page_base),
    .slot_valid(slot_valid), .slot_data(slot_data)
  );

  prom_store #(.AW(MEM_AW), .DW(DATA_W), .PW(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .page_base(page_base),
    .slot_valid(slot_valid), .slot_data(slot_data), .lock(lock_q),
    .wc(wc_lat), .rd_addr(ptr), .rd_data(rd_data), .commit_hit(commit_hit)
  );

  prom_guard #(.BUSY_CYCLES(BUSY_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .commit_hit(commit_hit),
    .lock_q(lock_q), .busy(busy)
  );

  // R9: write-control latched high lets nothing into the array
  p_wc_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && wc_lat) |-> !commit_hit);

  // R8: locked lower half never receives a commit
  p_low_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && lock_q && !page_base[MEM_AW-PAGE_W-1]) |-> !commit_hit);

endmodule

// File: tb/tb_i2c_prom_slave.sv
module tb_i2c_prom_slave;

  localparam int BUSY = 1500;
  localparam int H = 10;
  localparam int Q = 5;
  localparam logic [2:0] SEL = 3'b101;

  typedef struct { logic [7:0] val; string tag; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wc = 1'b0;
  logic pull;
  logic sda_bus;

  item_t exp_q[$];
  logic [7:0] act_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  bit ref_lock;
  bit last_hit;
  logic [7:0] wdat [32];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~pull;

  i2c_prom_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(pull), .dev_sel_i(SEL), .wr_ctrl_i(wc)
  );

  // Monitor: pair each observed value with the oldest expectation.
  always @(negedge clk) begin : mon
    item_t e;
    logic [7:0] a;
    while (act_q.size() > 0) begin
      a = act_q.pop_front();
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unmatched observation got %02h exp none", a);
      end else begin
        e = exp_q.pop_front();
        if (a !== e.val) begin
          n_bad++;
          $display("FAIL %s got %02h exp %02h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(logic [7:0] v, string t);
    item_t it;
    it.val = v;
    it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic bus_start();
    wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  // Sends a byte, records 1 if the slave acknowledged.
  task automatic put_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); sda_m = b[i]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    end
    wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    act_q.push_back({7'd0, ~sda_bus});
    wt(Q); scl = 1'b0;
  endtask

  task automatic get_byte(bit m_ack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(Q); b[i] = sda_bus; wt(Q); scl = 1'b0;
    end
    act_q.push_back(b);
    wt(Q); sda_m = ~m_ack; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    wt(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_w(logic [3:0] pfx);
    return {pfx, SEL, 1'b0};
  endfunction

  function automatic logic [7:0] dev_r(logic [3:0] pfx);
    return {pfx, SEL, 1'b1};
  endfunction

  // Memory write of n bytes from wdat at address a; model per R3/R4/R8/R9.
  task automatic wr_txn(logic [7:0] a, int n, bit wc_v, string t);
    logic [7:0] slot [16];
    bit sv [16];
    logic [7:0] p;
    logic [7:0] ad;
    wc = wc_v;
    bus_start();
    expect_v(8'd1, {t, " dev ack"}); put_byte(dev_w(4'b1010));
    expect_v(8'd1, {t, " addr ack"}); put_byte(a);
    for (int k = 0; k < 16; k++) sv[k] = 0;
    p = a;
    for (int k = 0; k < n; k++) begin
      expect_v(8'd1, {t, " data ack"}); put_byte(wdat[k]);
      slot[p[3:0]] = wdat[k];
      sv[p[3:0]] = 1;
      p = {p[7:4], p[3:0] + 4'd1};
    end
    bus_stop();
    wc = 1'b0;
    last_hit = 0;
    if (!wc_v) begin
      for (int s = 0; s < 16; s++) begin
        ad = {a[7:4], s[3:0]};
        if (sv[s] && !(ref_lock && !ad[7])) begin
          ref_mem[ad] = slot[s];
          last_hit = 1;
        end
      end
    end
    ref_ptr = p;
  endtask

  task automatic settle();
    if (last_hit) wt(BUSY + 40);
    last_hit = 0;
  endtask

  // Random read of n bytes from a; optional probe clock after the NACK (R7).
  task automatic rd_seq(logic [7:0] a, int n, bit probe, string t);
    bus_start();
    expect_v(8'd1, {t, " dev ack"}); put_byte(dev_w(4'b1010));
    expect_v(8'd1, {t, " addr ack"}); put_byte(a);
    bus_start();
    expect_v(8'd1, {t, " rd dev ack"}); put_byte(dev_r(4'b1010));
    for (int k = 0; k < n; k++) begin
      expect_v(ref_mem[8'(a + k)], $sformatf("%s byte %0d", t, k));
      get_byte(k != n - 1);
    end
    ref_ptr = 8'(a + n);
    if (probe) begin
      expect_v(8'd1, {t, " SDA released after NACK"});
      wt(H); scl = 1'b1; wt(Q); act_q.push_back({7'd0, sda_bus}); wt(Q); scl = 1'b0;
    end
    bus_stop();
  endtask

  task automatic rd_cur(int n, string t);
    bus_start();
    expect_v(8'd1, {t, " rd dev ack"}); put_byte(dev_r(4'b1010));
    for (int k = 0; k < n; k++) begin
      expect_v(ref_mem[ref_ptr], $sformatf("%s byte %0d", t, k));
      get_byte(k != n - 1);
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int k = 0; k < 256; k++) ref_mem[k] = 8'hFF;
    ref_ptr = 8'h00;
    ref_lock = 0;
    last_hit = 0;
    wt(5);
    // R12: reset leaves SDA released
    expect_v(8'd0, "R12 pull after reset"); act_q.push_back({7'd0, pull});
    rst_n = 1'b1;
    wt(10);

    // R12/R6: erased array, pointer at 0x00
    rd_cur(1, "R12 erased read at reset pointer");

    // R1: bits without START are not acknowledged
    wt(Q); scl = 1'b0;
    expect_v(8'd0, "R1 no ack without START"); put_byte(dev_w(4'b1010));
    bus_stop();

    // R2: wrong select and wrong prefix
    bus_start();
    expect_v(8'd0, "R2 wrong select nack"); put_byte({4'b1010, 3'b010, 1'b0});
    bus_stop();
    bus_start();
    expect_v(8'd0, "R2 wrong prefix nack"); put_byte({4'b1011, SEL, 1'b0});
    bus_stop();
    // R13: alternate prefix with read
    bus_start();
    expect_v(8'd0, "R13 lock prefix read nack"); put_byte(dev_r(4'b0110));
    bus_stop();

    // R3: single byte write
    wdat[0] = 8'h5A;
    wr_txn(8'h10, 1, 1'b0, "R3 byte write");
    // R11: busy window right after a committed write
    bus_start();
    expect_v(8'd0, "R11 nack while busy"); put_byte(dev_r(4'b1010));
    bus_stop();
    settle();
    rd_seq(8'h10, 1, 1'b0, "R3 readback");

    // R4: 18-byte burst wraps in page 0xA0
    for (int k = 0; k < 18; k++) wdat[k] = 8'(8'h30 + k);
    wr_txn(8'hAE, 18, 1'b0, "R4 page write");
    settle();
    rd_seq(8'hA0, 16, 1'b0, "R4 page readback");

    // R6: pointer wraps 0xFF -> 0x00, then current read continues
    wdat[0] = 8'h77;
    wr_txn(8'hFF, 1, 1'b0, "R6 write top");
    settle();
    rd_seq(8'hFF, 2, 1'b0, "R6 wrap read");
    rd_cur(1, "R6 current read after wrap");

    // R5: repeated START discards buffered data
    bus_start();
    expect_v(8'd1, "R5 dev ack"); put_byte(dev_w(4'b1010));
    expect_v(8'd1, "R5 addr ack"); put_byte(8'h30);
    expect_v(8'd1, "R5 data ack"); put_byte(8'h99);
    bus_start();
    expect_v(8'd1, "R5 no busy after abort"); put_byte(dev_r(4'b1010));
    expect_v(ref_mem[8'h31], "R5 current read after abort"); get_byte(1'b0);
    bus_stop();
    rd_seq(8'h30, 1, 1'b1, "R5 R7 aborted byte not stored");

    // R9: write-control high at START blocks the write, no busy window
    wdat[0] = 8'hC3;
    wr_txn(8'h40, 1, 1'b1, "R9 blocked write");
    rd_seq(8'h40, 1, 1'b0, "R9 R11 readback immediate");

    // R10: write-control raised after START has no effect
    wc = 1'b0;
    bus_start();
    expect_v(8'd1, "R10 dev ack"); put_byte(dev_w(4'b1010));
    wc = 1'b1;
    expect_v(8'd1, "R10 addr ack"); put_byte(8'h41);
    expect_v(8'd1, "R10 data ack"); put_byte(8'h3C);
    bus_stop();
    wc = 1'b0;
    ref_mem[8'h41] = 8'h3C;
    wt(BUSY + 40);
    rd_seq(8'h41, 1, 1'b0, "R10 readback");

    // R9: lock command with write-control high does not lock
    wc = 1'b1;
    bus_start();
    expect_v(8'd1, "R9 lock cmd ack"); put_byte(dev_w(4'b0110));
    bus_stop();
    wc = 1'b0;
    wdat[0] = 8'hA5;
    wr_txn(8'h05, 1, 1'b0, "R9 low write still open");
    settle();
    rd_seq(8'h05, 1, 1'b0, "R9 low readback");

    // R8: real lock
    bus_start();
    expect_v(8'd1, "R8 lock cmd ack"); put_byte(dev_w(4'b0110));
    expect_v(8'd1, "R8 lock extra byte ack"); put_byte(8'h00);
    bus_stop();
    ref_lock = 1;
    wdat[0] = 8'h12;
    wr_txn(8'h06, 1, 1'b0, "R8 locked low write");
    rd_seq(8'h06, 1, 1'b0, "R8 R11 low dropped no busy");
    wdat[0] = 8'h34;
    wr_txn(8'h86, 1, 1'b0, "R8 upper write");
    settle();
    rd_seq(8'h86, 1, 1'b0, "R8 upper readback");
    rd_seq(8'h05, 1, 1'b0, "R8 earlier low data kept");

    wt(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule